// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scanner with PWM Dimming

This block time-multiplexes a row of up to eight common-cathode seven-segment digits. It steps through the digits one slot at a time. While a digit's slot is open, it pulls that digit's cathode enable low and drives eight segment lines: a to g and the decimal point. The pattern on those lines comes either from a font decoder or straight from the stored digit byte, and the choice is made per digit. Brightness is set by gating the segments on for only part of each slot.

The inputs are the current contents of the display registers, the control inputs and a blanking request from a blink controller. The control inputs are decode mask, font select, intensity, scan limit, shutdown and test. Each slot is split into 32 sub-ticks of `TICK_CYCLES` clocks each. Sub-tick 0 of every slot is always dark, so no segment stays lit across a change of digit. The outputs are a function of the scan counters and the present inputs, so a change of any data or control input shows in the same cycle.

Top module: `seg_scan_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, the scan is at digit 0, sub-tick 0. With shutdown low, `digit_n` reads 8'hFE and `seg_en` reads 0.
- R2: With scan limit N, digits 0..N are enabled in turn, each for one slot of 32*TICK_CYCLES clocks, and digits above N are never enabled. `digit_n` is active low with at most one bit low.
- R3: For intensity nibble k, a scanned digit's segments are lit for (2k+1) sub-ticks of each 32-sub-tick slot. These are sub-ticks 1 to 2k+1.
- R4: Sub-tick 0 of every slot is dark. Whenever the enabled digit changes from one digit to another, `seg_en` is 0 in that cycle.
- R5: Bit i of `decode_en` selects decoding for digit i. A decoded digit uses data bits 3:0 for the character, ignores bits 6:4 and drives the decimal point from bit 7.
- R6: With `hex_font` low, the decoded characters are as follows (`seg_en` bits 6..0 = a..g): values 0..9 give 7E,30,6D,79,33,5B,5F,70,7F,7B; 10 gives dash 01; 11 gives E 4F; 12 gives H 37; 13 gives L 0E; 14 gives P 67; 15 gives blank 00.
- R7: With `hex_font` high, values 0..9 are as in R6. Values 10..15 give A 77, b 1F, C 4E, d 3D, E 4F and F 47.
- R8: Without decoding, data bit 7 drives `seg_en[7]` (decimal point) and data bits 6..0 drive `seg_en[6:0]` (segments a..g).
- R9: With `test_mode` high, every segment of each scanned digit is lit at the maximum duty of 31 sub-ticks per slot. This overrides shutdown and blanking, and when test mode is left the display returns to its stored contents.
- R10: With `shutdown` high and `test_mode` low, `digit_n` is 8'hFF and `seg_en` is 0. The stored contents reappear unchanged after shutdown is released.
- R11: With `blink_blank` high and `test_mode` low, `seg_en` is 0 for the whole slot while the digit scan continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the scan counters |
| digit_data | input | 8*NUM_DIGITS | Digit bytes, digit i in bits 8i+7:8i |
| decode_en | input | NUM_DIGITS | Per-digit font decode enable |
| hex_font | input | 1 | 0 = special-character font, 1 = hexadecimal font |
| intensity | input | 4 | Duty nibble k, on-time (2k+1)/32 |
| scan_limit | input | $clog2(NUM_DIGITS) | Highest digit index scanned |
| shutdown | input | 1 | Turns all digits and segments off |
| test_mode | input | 1 | Lights all segments at full duty |
| blink_blank | input | 1 | Blanks segments while high |
| digit_n | output | NUM_DIGITS | Active-low one-hot digit enables |
| seg_en | output | 8 | Segment enables, bit 7 = dp, bits 6..0 = a..g |

## Verification
The bench aims at the ends of the duty law (k = 0 and k = 15) and at the intermediate k = 5. A design with an off-by-one window would light 1 or 2 sub-ticks too many there, or would lose the dark guard sub-tick. It reads every special character of both fonts and a decoded byte with junk in bits 6:4, which catches a decoder that leaks the upper nibble or has its font tables swapped. A scan with a limit below the maximum checks that no unscanned digit is ever enabled. The combinations of test with shutdown and of test with blanking check the priority order, where a design giving shutdown the higher priority would stay dark.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    localparam int SUB_STEPS = 32;
    localparam int SUB_W     = 5;

    // seven-segment pattern, bit 6 = a ... bit 0 = g
    function automatic logic [6:0] font_special(input logic [3:0] v);
        logic [6:0] p;
        case (v)
            4'd0:  p = 7'h7E;
            4'd1:  p = 7'h30;
            4'd2:  p = 7'h6D;
            4'd3:  p = 7'h79;
            4'd4:  p = 7'h33;
            4'd5:  p = 7'h5B;
            4'd6:  p = 7'h5F;
            4'd7:  p = 7'h70;
            4'd8:  p = 7'h7F;
            4'd9:  p = 7'h7B;
            4'd10: p = 7'h01;
            4'd11: p = 7'h4F;
            4'd12: p = 7'h37;
            4'd13: p = 7'h0E;
            4'd14: p = 7'h67;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

    function automatic logic [6:0] font_hex(input logic [3:0] v);
        logic [6:0] p;
        case (v)
            4'd10: p = 7'h77;
            4'd11: p = 7'h1F;
            4'd12: p = 7'h4E;
            4'd13: p = 7'h3D;
            4'd14: p = 7'h4F;
            4'd15: p = 7'h47;
            default: p = font_special(v);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
    parameter int NUM_DIGITS  = 8,
    parameter int TICK_CYCLES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NUM_DIGITS)-1:0] scan_limit,
    output logic [$clog2(NUM_DIGITS)-1:0] dig_idx,
    output logic [seg_scan_pkg::SUB_W-1:0] sub_idx
);
    import seg_scan_pkg::*;

    localparam int DIG_W  = $clog2(NUM_DIGITS);
    localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [DIG_W-1:0]  LAST_DIG  = DIG_W'(NUM_DIGITS - 1);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICK_CYCLES - 1);
    localparam logic [SUB_W-1:0]  LAST_SUB  = SUB_W'(SUB_STEPS - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [SUB_W-1:0]  sub;
        logic [DIG_W-1:0]  dig;
    } timer_t;

    timer_t s_d, s_q;
    logic [DIG_W-1:0] lim_eff;

    always_comb begin
        lim_eff = (scan_limit > LAST_DIG) ? LAST_DIG : scan_limit;
        s_d = s_q;
        if (s_q.tick == LAST_TICK) begin
            s_d.tick = '0;
            if (s_q.sub == LAST_SUB) begin
                s_d.sub = '0;
                s_d.dig = (s_q.dig >= lim_eff) ? '0 : s_q.dig + 1'b1;
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end else begin
            s_d.tick = s_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dig_idx = s_q.dig;
    assign sub_idx = s_q.sub;

endmodule

// File: rtl/seg_font_dec.sv
module seg_font_dec (
    input  logic [7:0] data,
    input  logic       decode,
    input  logic       hex_font,
    output logic [7:0] pattern
);
    import seg_scan_pkg::*;

    always_comb begin
        if (!decode)       pattern = data;
        else if (hex_font) pattern = {data[7], font_hex(data[3:0])};
        else               pattern = {data[7], font_special(data[3:0])};
    end

endmodule

// File: rtl/seg_pwm_gate.sv
module seg_pwm_gate (
    input  logic [seg_scan_pkg::SUB_W-1:0] sub_idx,
    input  logic [3:0]                     intensity,
    input  logic                           full_duty,
    output logic                           on
);
    import seg_scan_pkg::*;

    logic [SUB_W-1:0] last_on;

    always_comb begin
        last_on = full_duty ? SUB_W'(SUB_STEPS - 1) : {intensity, 1'b1};
        on = (sub_idx != '0) && (sub_idx <= last_on);
    end

endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top #(
    parameter int NUM_DIGITS  = 8,
    parameter int TICK_CYCLES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [8*NUM_DIGITS-1:0]       digit_data,
    input  logic [NUM_DIGITS-1:0]         decode_en,
    input  logic                          hex_font,
    input  logic [3:0]                    intensity,
    input  logic [$clog2(NUM_DIGITS)-1:0] scan_limit,
    input  logic                          shutdown,
    input  logic                          test_mode,
    input  logic                          blink_blank,
    output logic [NUM_DIGITS-1:0]         digit_n,
    output logic [7:0]                    seg_en
);
    import seg_scan_pkg::*;

    localparam int DIG_W = $clog2(NUM_DIGITS);

    logic [DIG_W-1:0] dig_idx;
    logic [SUB_W-1:0] sub_idx;
    logic [7:0]       dig_bytes [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] onehot;
    logic [7:0]       cur_byte;
    logic [7:0]       font_pat;
    logic             pwm_on;
    logic             digit_live;
    logic             seg_live;

    seg_scan_timer #(
        .NUM_DIGITS (NUM_DIGITS),
        .TICK_CYCLES(TICK_CYCLES)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_limit(scan_limit),
        .dig_idx   (dig_idx),
        .sub_idx   (sub_idx)
    );

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
        assign dig_bytes[i] = digit_data[8*i +: 8];
        assign onehot[i]    = (dig_idx == DIG_W'(i));
    end

    assign cur_byte = dig_bytes[dig_idx];

    seg_font_dec dec_i (
        .data    (cur_byte),
        .decode  (decode_en[dig_idx]),
        .hex_font(hex_font),
        .pattern (font_pat)
    );

    seg_pwm_gate pwm_i (
        .sub_idx  (sub_idx),
        .intensity(intensity),
        .full_duty(test_mode),
        .on       (pwm_on)
    );

    always_comb begin
        digit_live = test_mode || !shutdown;
        seg_live   = pwm_on && (test_mode || (!shutdown && !blink_blank));
        digit_n    = digit_live ? ~onehot : '1;
        if (!seg_live)      seg_en = 8'h00;
        else if (test_mode) seg_en = 8'hFF;
        else                seg_en = font_pat;
    end

endmodule

// File: rtl/seg_scan_checker.sv
module seg_scan_checker #(
    parameter int NUM_DIGITS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  shutdown,
    input logic                  test_mode,
    input logic                  blink_blank,
    input logic [NUM_DIGITS-1:0] digit_n,
    input logic [7:0]            seg_en
);

    a_r2_digit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~digit_n));

    a_r4_dark_on_digit_change: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_n != '1 && $past(digit_n) != '1 && digit_n != $past(digit_n))
        |-> seg_en == 8'h00);

    a_r9_test_full_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (digit_n != '1 && (seg_en == 8'h00 || seg_en == 8'hFF)));

    a_r10_shutdown_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !test_mode) |-> (digit_n == '1 && seg_en == 8'h00));

    a_r11_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_blank && !test_mode) |-> seg_en == 8'h00);

    a_r2_segs_need_digit: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en != 8'h00) |-> digit_n != '1);

endmodule

bind seg_scan_top seg_scan_checker #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shutdown   (shutdown),
    .test_mode  (test_mode),
    .blink_blank(blink_blank),
    .digit_n    (digit_n),
    .seg_en     (seg_en)
);

// File: tb/seg_scan_top_tb_top.sv
`timescale 1ns/1ps
module seg_scan_top_tb_top;

    localparam int ND   = 8;
    localparam int TC   = 2;
    localparam int SLOT = 32 * TC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [8*ND-1:0] digit_data = '0;
    logic [ND-1:0] decode_en = '0;
    logic          hex_font = 1'b0;
    logic [3:0]    intensity = 4'hF;
    logic [2:0]    scan_limit = 3'd0;
    logic          shutdown = 1'b0;
    logic          test_mode = 1'b0;
    logic          blink_blank = 1'b0;
    logic [ND-1:0] digit_n;
    logic [7:0]    seg_en;

    int checks = 0;
    int errors = 0;
    int obs_or, obs_any_or, obs_on, obs_act, obs_dark;
    int ghost_viol = 0;
    logic [ND-1:0] prev_dn = '1;

    always #5 clk = ~clk;

    seg_scan_top #(.NUM_DIGITS(ND), .TICK_CYCLES(TC)) dut_i (
        .clk(clk), .rst_n(rst_n), .digit_data(digit_data), .decode_en(decode_en),
        .hex_font(hex_font), .intensity(intensity), .scan_limit(scan_limit),
        .shutdown(shutdown), .test_mode(test_mode), .blink_blank(blink_blank),
        .digit_n(digit_n), .seg_en(seg_en)
    );

    // vector: [17:10] data, [9] decode, [8] hex font, [7:0] expected seg_en
    localparam logic [17:0] VEC [18] = '{
        {8'h00, 1'b1, 1'b0, 8'h7E},   // R6 zero
        {8'h09, 1'b1, 1'b0, 8'h7B},   // R6 nine
        {8'h0A, 1'b1, 1'b0, 8'h01},   // R6 dash
        {8'h0B, 1'b1, 1'b0, 8'h4F},   // R6 E
        {8'h0C, 1'b1, 1'b0, 8'h37},   // R6 H
        {8'h0D, 1'b1, 1'b0, 8'h0E},   // R6 L
        {8'h0E, 1'b1, 1'b0, 8'h67},   // R6 P
        {8'h0F, 1'b1, 1'b0, 8'h00},   // R6 blank
        {8'h7A, 1'b1, 1'b0, 8'h01},   // R5 bits 6:4 ignored
        {8'h85, 1'b1, 1'b0, 8'hDB},   // R5 dp from bit 7
        {8'h04, 1'b1, 1'b1, 8'h33},   // R7 four
        {8'h0A, 1'b1, 1'b1, 8'h77},   // R7 A
        {8'h0B, 1'b1, 1'b1, 8'h1F},   // R7 b
        {8'h0C, 1'b1, 1'b1, 8'h4E},   // R7 C
        {8'h0D, 1'b1, 1'b1, 8'h3D},   // R7 d
        {8'h0F, 1'b1, 1'b1, 8'h47},   // R7 F
        {8'h3C, 1'b0, 1'b0, 8'h3C},   // R8 raw
        {8'hA5, 1'b0, 1'b1, 8'hA5}    // R8 raw, font select irrelevant
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic observe(input int cycles, input int dig);
        obs_or = 0; obs_any_or = 0; obs_on = 0; obs_act = 0; obs_dark = 0;
        repeat (cycles) begin
            @(negedge clk);
            obs_any_or |= int'(seg_en);
            if (digit_n == '1) obs_dark++;
            if (digit_n == ~(ND'(1) << dig)) begin
                obs_act++;
                obs_or |= int'(seg_en);
                if (seg_en != 8'h00) obs_on++;
            end
        end
    endtask

    // R4 monitor: digit-to-digit change must coincide with dark segments
    always @(negedge clk) begin
        if (rst_n && digit_n != '1 && prev_dn != '1 && digit_n != prev_dn && seg_en != 8'h00)
            ghost_viol++;
        prev_dn = digit_n;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(digit_n == 8'hFE, "R1 digit_n in reset", int'(digit_n), 8'hFE);
        chk(seg_en == 8'h00, "R1 seg_en in reset", int'(seg_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(digit_n == 8'hFE && seg_en == 8'h00, "R1 first cycle after reset",
            int'({digit_n, seg_en}), 16'hFE00);

        // font and no-decode vectors on digit 0 at full intensity
        for (int i = 0; i < 18; i++) begin
            digit_data[7:0] = VEC[i][17:10];
            decode_en[0]    = VEC[i][9];
            hex_font        = VEC[i][8];
            observe(SLOT, 0);
            chk(obs_or == int'(VEC[i][7:0]), $sformatf("R5/R6/R7/R8 vector %0d", i),
                obs_or, int'(VEC[i][7:0]));
        end

        // R3 duty law
        decode_en = '0; digit_data[7:0] = 8'hFF; hex_font = 1'b0;
        intensity = 4'd0;  observe(SLOT, 0);
        chk(obs_on == 1 * TC, "R3 k=0 on cycles", obs_on, 1 * TC);
        intensity = 4'd5;  observe(SLOT, 0);
        chk(obs_on == 11 * TC, "R3 k=5 on cycles", obs_on, 11 * TC);
        intensity = 4'd15; observe(SLOT, 0);
        chk(obs_on == 31 * TC, "R3 k=15 on cycles", obs_on, 31 * TC);

        // R5 per-digit decode selection
        scan_limit = 3'd1;
        digit_data[15:0] = 16'h0303;
        decode_en = 8'h01;
        repeat (ND * SLOT) @(negedge clk);
        observe(2 * SLOT, 0);
        chk(obs_or == 8'h79, "R5 digit0 decoded", obs_or, 8'h79);
        observe(2 * SLOT, 1);
        chk(obs_or == 8'h03, "R5 digit1 raw", obs_or, 8'h03);

        // R2 scan limit
        scan_limit = 3'd2;
        digit_data = {8{8'hFF}};
        decode_en = '0;
        repeat (ND * SLOT) @(negedge clk);
        for (int d = 0; d < ND; d++) begin
            observe(3 * SLOT, d);
            chk(obs_act == ((d <= 2) ? SLOT : 0), $sformatf("R2 limit 2 digit %0d slot", d),
                obs_act, (d <= 2) ? SLOT : 0);
        end
        scan_limit = 3'd7;
        repeat (ND * SLOT) @(negedge clk);
        observe(ND * SLOT, 7);
        chk(obs_act == SLOT, "R2 limit 7 digit 7 slot", obs_act, SLOT);
        observe(ND * SLOT, 5);
        chk(obs_on == 31 * TC, "R4 guard sub-tick dark on digit 5", obs_on, 31 * TC);
        chk(ghost_viol == 0, "R4 dark at digit change", ghost_viol, 0);

        // back to single digit
        scan_limit = 3'd0;
        digit_data[7:0] = 8'h85;
        decode_en = 8'h01;
        repeat (ND * SLOT) @(negedge clk);

        // R10 shutdown
        shutdown = 1'b1;
        observe(SLOT, 0);
        chk(obs_dark == SLOT && obs_any_or == 0, "R10 shutdown dark", obs_dark, SLOT);
        // R9 test overrides shutdown
        test_mode = 1'b1;
        observe(SLOT, 0);
        chk(obs_on == 31 * TC && obs_or == 8'hFF, "R9 test over shutdown", obs_on, 31 * TC);
        test_mode = 1'b0;
        shutdown = 1'b0;
        observe(SLOT, 0);
        chk(obs_or == 8'hDB, "R10 contents kept after shutdown/test", obs_or, 8'hDB);

        // R11 blanking
        blink_blank = 1'b1;
        observe(SLOT, 0);
        chk(obs_any_or == 0 && obs_act == SLOT, "R11 blank keeps scan, segs dark",
            obs_any_or, 0);
        test_mode = 1'b1;
        observe(SLOT, 0);
        chk(obs_or == 8'hFF, "R9 test over blank", obs_or, 8'hFF);
        test_mode = 1'b0;
        blink_blank = 1'b0;
        observe(SLOT, 0);
        chk(obs_or == 8'hDB, "R9 contents back after test", obs_or, 8'hDB);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule